// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block controls one general-purpose I/O port of up to eight pins through a small synchronous register bus. Software sets pin direction and output level either by plain writes or through set, clear and toggle aliases. Incoming pin levels are sampled through a two-flop synchronizer and can be read back. Each pin has its own configuration byte that selects optional inversion, an input sense mode and an output drive mode. One masked write can load the same configuration into several pins at once.

Sense events set per-pin flags, and software clears a flag by writing a 1 to it. Two interrupt outputs are the OR of the flags selected by their own pin masks, each gated by an enable bit. Two fixed pins can carry a clock-out source or an event source in place of the output register. Pad electrical behaviour is reduced to an output-enable, a drive value and a weak pull request per pin. All pad-side and interrupt outputs come from registers.

Top module: `gpio_port_ctrl`

## Requirements
- R1: While `rst` is high, and until the first register write afterwards, `pin_oe`, `pin_out`, `pull_en`, `pull_hi` and `irq` are all 0, and every register reads back 0.
- R2: Word addresses 0 and 4 replace the direction and output registers. Addresses 1 and 5 set the bits written as 1, addresses 2 and 6 clear them, and addresses 3 and 7 toggle them. Bits written as 0 keep their value. Addresses 0 to 3 read back the direction register and addresses 4 to 7 read back the output register.
- R3: `bus_rdata` is registered and shows the word at `bus_addr` one clock later. Address 8 returns the synchronized pin levels, each XORed with that pin's invert bit (configuration bit 7).
- R4: Configuration bits [1:0] select the sense mode: 0 both edges, 1 rising, 2 falling, 3 low level. The mode acts on the inverted, synchronized value. A matching event sets that pin's flag at address 9 on the third rising clock edge after the pin changes.
- R5: Writing 1 to a bit at address 9 clears that flag. When a set and a clear fall in the same cycle, the set wins. A low-level pin therefore keeps its flag set for as long as it stays low.
- R6: Addresses 10 and 11 hold the pin masks for `irq[0]` and `irq[1]`, and bits [1:0] of address 12 enable them. Each `irq` bit is registered and rises one clock after an enabled, masked flag is set.
- R7: Address 13 holds a pin mask. A write to address 14 loads the written byte into the configuration of every masked pin and leaves the other pins unchanged. Pin i's configuration reads back at address 16+i, with bits 6 and 2 reading 0.
- R8: Configuration bits [5:3] select the drive mode: 0 totem-pole, 1 pull-down, 2 pull-up, 3 wired-AND, 4 wired-OR, 5 bus-keeper. With the direction bit set, the level is the output bit XORed with the invert bit. Totem-pole, pull and keeper modes drive that level. Wired-AND drives 0 only when the level is 0, and wired-OR drives 1 only when the level is 1. Pad outputs change one clock after the register change.
- R9: With the direction bit clear, `pull_en` and `pull_hi` request a weak pull: pull-down gives 1/0, pull-up gives 1/1, and bus-keeper gives 1 with `pull_hi` following the synchronized raw pin level. Other modes give 0/0.
- R10: Bit 0 of address 15 puts `clk_src` on pin 4 and bit 1 puts `evt_src` on pin 7, in place of the output register bit. The pin's invert bit still applies.
- R11: A pin whose direction bit is clear never has `pin_oe` high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register word address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad drive value |
| pin_oe | output | 8 | Pad output enable |
| pull_en | output | 8 | Weak pull request |
| pull_hi | output | 8 | Weak pull direction (1 = up) |
| clk_src | input | 1 | Clock-out source routed to pin 4 |
| evt_src | input | 1 | Event source routed to pin 7 |
| irq | output | 2 | Port interrupt lines |

## Verification
The sense logic is tested with rising, falling and steady-low pin patterns on pins set to different modes. This separates the rising-only, falling-only, both-edge and level behaviours. The same edges are repeated on an inverted pin to show that detection follows the inverted value. Interrupt timing is sampled one cycle before and on the expected edge, which catches an added or missing pipeline stage. Drive modes are tried with both output levels, because wired-AND and wired-OR differ from totem-pole only in which level leaves the pad undriven.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  typedef enum logic [1:0] {
    SNS_BOTH = 2'd0,
    SNS_RISE = 2'd1,
    SNS_FALL = 2'd2,
    SNS_LOW  = 2'd3
  } sense_e;

  typedef enum logic [2:0] {
    DRV_TOTEM  = 3'd0,
    DRV_PULLDN = 3'd1,
    DRV_PULLUP = 3'd2,
    DRV_WAND   = 3'd3,
    DRV_WOR    = 3'd4,
    DRV_KEEP   = 3'd5
  } drive_e;

  typedef struct packed {
    logic   inv;
    drive_e drv;
    sense_e sns;
  } pin_cfg_t;

  localparam int A_DIR      = 0;
  localparam int A_DIR_SET  = 1;
  localparam int A_DIR_CLR  = 2;
  localparam int A_DIR_TGL  = 3;
  localparam int A_OUT      = 4;
  localparam int A_OUT_SET  = 5;
  localparam int A_OUT_CLR  = 6;
  localparam int A_OUT_TGL  = 7;
  localparam int A_IN       = 8;
  localparam int A_FLAGS    = 9;
  localparam int A_IRQ0_MSK = 10;
  localparam int A_IRQ1_MSK = 11;
  localparam int A_IRQ_EN   = 12;
  localparam int A_CFG_MSK  = 13;
  localparam int A_CFG_WR   = 14;
  localparam int A_ROUTE    = 15;
  localparam int A_CFG_BASE = 16;

  function automatic pin_cfg_t cfg_unpack(input logic [7:0] b);
    pin_cfg_t c;
    c.inv = b[7];
    c.drv = drive_e'(b[5:3]);
    c.sns = sense_e'(b[1:0]);
    return c;
  endfunction

  function automatic logic [7:0] cfg_pack(input pin_cfg_t c);
    return {c.inv, 1'b0, c.drv, 1'b0, c.sns};
  endfunction

endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int PINS = 8,
  parameter int DW   = 8,
  parameter int AW   = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_we,
  input  logic [AW-1:0]        bus_addr,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  input  logic [PINS-1:0]      in_val,
  input  logic [PINS-1:0]      flags,
  output logic [PINS-1:0]      flag_clr,
  output logic [PINS-1:0]      dir_q,
  output logic [PINS-1:0]      out_q,
  output pin_cfg_t [PINS-1:0]  cfg_q,
  output logic [PINS-1:0]      msk0_q,
  output logic [PINS-1:0]      msk1_q,
  output logic [1:0]           irq_en_q,
  output logic [1:0]           route_q
);

  logic [PINS-1:0] cfg_msk_q;
  logic [PINS-1:0] wd;
  logic [DW-1:0]   rd_next;
  logic [AW-1:0]   cfg_idx;
  int              a;

  assign wd       = bus_wdata[PINS-1:0];
  assign a        = int'(bus_addr);
  assign cfg_idx  = bus_addr - AW'(A_CFG_BASE);
  assign flag_clr = (bus_we && a == A_FLAGS) ? wd : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q     <= '0;
      out_q     <= '0;
      msk0_q    <= '0;
      msk1_q    <= '0;
      irq_en_q  <= '0;
      route_q   <= '0;
      cfg_msk_q <= '0;
      cfg_q     <= '0;
    end else if (bus_we) begin
      case (a)
        A_DIR:      dir_q     <= wd;
        A_DIR_SET:  dir_q     <= dir_q | wd;
        A_DIR_CLR:  dir_q     <= dir_q & ~wd;
        A_DIR_TGL:  dir_q     <= dir_q ^ wd;
        A_OUT:      out_q     <= wd;
        A_OUT_SET:  out_q     <= out_q | wd;
        A_OUT_CLR:  out_q     <= out_q & ~wd;
        A_OUT_TGL:  out_q     <= out_q ^ wd;
        A_IRQ0_MSK: msk0_q    <= wd;
        A_IRQ1_MSK: msk1_q    <= wd;
        A_IRQ_EN:   irq_en_q  <= bus_wdata[1:0];
        A_CFG_MSK:  cfg_msk_q <= wd;
        A_ROUTE:    route_q   <= bus_wdata[1:0];
        A_CFG_WR: begin
          for (int i = 0; i < PINS; i++)
            if (cfg_msk_q[i]) cfg_q[i] <= cfg_unpack(bus_wdata[7:0]);
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_next = '0;
    case (a)
      A_DIR, A_DIR_SET, A_DIR_CLR, A_DIR_TGL: rd_next[PINS-1:0] = dir_q;
      A_OUT, A_OUT_SET, A_OUT_CLR, A_OUT_TGL: rd_next[PINS-1:0] = out_q;
      A_IN:       rd_next[PINS-1:0] = in_val;
      A_FLAGS:    rd_next[PINS-1:0] = flags;
      A_IRQ0_MSK: rd_next[PINS-1:0] = msk0_q;
      A_IRQ1_MSK: rd_next[PINS-1:0] = msk1_q;
      A_IRQ_EN:   rd_next[1:0]      = irq_en_q;
      A_CFG_MSK:  rd_next[PINS-1:0] = cfg_msk_q;
      A_ROUTE:    rd_next[1:0]      = route_q;
      default: begin
        if (a >= A_CFG_BASE && a < A_CFG_BASE + PINS)
          rd_next[7:0] = cfg_pack(cfg_q[cfg_idx]);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

  p_set_alias_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_we && a == A_OUT_SET) |=> ((out_q & $past(wd)) == $past(wd)));

  p_tgl_alias_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_we && a == A_DIR_TGL) |=> (dir_q == ($past(dir_q) ^ $past(wd))));

  generate
    for (genvar g = 0; g < PINS; g++) begin : g_cfg_chk
      p_cfg_keep_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_we && a == A_CFG_WR && !cfg_msk_q[g]) |=> $stable(cfg_q[g]));
    end
  endgenerate

endmodule

// File: rtl/gpio_sense.sv
module gpio_sense
  import gpio_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [PINS-1:0]      pin_in,
  input  pin_cfg_t [PINS-1:0]  cfg,
  input  logic [PINS-1:0]      flag_clr,
  output logic [PINS-1:0]      in_val,
  output logic [PINS-1:0]      sync_raw,
  output logic [PINS-1:0]      flags
);

  logic [PINS-1:0] s1_q, s2_q, prev_q, hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= pin_in;
      s2_q <= s1_q;
    end
  end

  assign sync_raw = s2_q;

  generate
    for (genvar g = 0; g < PINS; g++) begin : g_pin
      assign in_val[g] = s2_q[g] ^ cfg[g].inv;
      always_comb begin
        case (cfg[g].sns)
          SNS_BOTH: hit[g] = in_val[g] ^ prev_q[g];
          SNS_RISE: hit[g] = in_val[g] & ~prev_q[g];
          SNS_FALL: hit[g] = ~in_val[g] & prev_q[g];
          default:  hit[g] = ~in_val[g];
        endcase
      end

      p_low_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg[g].sns == SNS_LOW && !in_val[g]) |=> flags[g]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      flags  <= '0;
    end else begin
      prev_q <= in_val;
      flags  <= (flags & ~flag_clr) | hit;
    end
  end

endmodule

// File: rtl/gpio_drive.sv
module gpio_drive
  import gpio_pkg::*;
#(
  parameter int PINS    = 8,
  parameter int CLK_PIN = 4,
  parameter int EVT_PIN = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [PINS-1:0]      dir,
  input  logic [PINS-1:0]      out,
  input  pin_cfg_t [PINS-1:0]  cfg,
  input  logic [1:0]           route,
  input  logic                 clk_src,
  input  logic                 evt_src,
  input  logic [PINS-1:0]      sync_raw,
  output logic [PINS-1:0]      pin_out,
  output logic [PINS-1:0]      pin_oe,
  output logic [PINS-1:0]      pull_en,
  output logic [PINS-1:0]      pull_hi
);

  logic [PINS-1:0] src, lvl, oe_n, val_n, pen_n, phi_n;

  generate
    for (genvar g = 0; g < PINS; g++) begin : g_pin
      if (g == CLK_PIN && g == EVT_PIN) begin : g_both
        assign src[g] = route[1] ? evt_src : (route[0] ? clk_src : out[g]);
      end else if (g == CLK_PIN) begin : g_clk
        assign src[g] = route[0] ? clk_src : out[g];
      end else if (g == EVT_PIN) begin : g_evt
        assign src[g] = route[1] ? evt_src : out[g];
      end else begin : g_plain
        assign src[g] = out[g];
      end

      assign lvl[g] = src[g] ^ cfg[g].inv;

      always_comb begin
        oe_n[g]  = 1'b0;
        val_n[g] = 1'b0;
        pen_n[g] = 1'b0;
        phi_n[g] = 1'b0;
        if (dir[g]) begin
          case (cfg[g].drv)
            DRV_WAND: begin oe_n[g] = ~lvl[g]; val_n[g] = 1'b0; end
            DRV_WOR:  begin oe_n[g] = lvl[g];  val_n[g] = 1'b1; end
            default:  begin oe_n[g] = 1'b1;    val_n[g] = lvl[g]; end
          endcase
        end else begin
          case (cfg[g].drv)
            DRV_PULLDN: begin pen_n[g] = 1'b1; phi_n[g] = 1'b0; end
            DRV_PULLUP: begin pen_n[g] = 1'b1; phi_n[g] = 1'b1; end
            DRV_KEEP:   begin pen_n[g] = 1'b1; phi_n[g] = sync_raw[g]; end
            default: ;
          endcase
        end
      end

      p_dir_off_r11: assert property (@(posedge clk) disable iff (rst)
        !$past(dir[g]) |-> !pin_oe[g]);

      p_wand_low_r8: assert property (@(posedge clk) disable iff (rst)
        (pin_oe[g] && $past(dir[g] && cfg[g].drv == DRV_WAND)) |-> !pin_out[g]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= '0;
      pin_oe  <= '0;
      pull_en <= '0;
      pull_hi <= '0;
    end else begin
      pin_out <= val_n;
      pin_oe  <= oe_n;
      pull_en <= pen_n;
      pull_hi <= phi_n;
    end
  end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_pkg::*;
#(
  parameter int PINS    = 8,
  parameter int CLK_PIN = 4,
  parameter int EVT_PIN = PINS - 1,
  localparam int DW     = (PINS < 8) ? 8 : PINS,
  localparam int AW     = $clog2(A_CFG_BASE + PINS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [PINS-1:0] pin_in,
  output logic [PINS-1:0] pin_out,
  output logic [PINS-1:0] pin_oe,
  output logic [PINS-1:0] pull_en,
  output logic [PINS-1:0] pull_hi,
  input  logic            clk_src,
  input  logic            evt_src,
  output logic [1:0]      irq
);

  logic [PINS-1:0]     in_val, sync_raw, flags, flag_clr;
  logic [PINS-1:0]     dir_q, out_q, msk0_q, msk1_q;
  logic [1:0]          irq_en_q, route_q, irq_n;
  pin_cfg_t [PINS-1:0] cfg_q;

  gpio_regs #(.PINS(PINS), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .in_val(in_val),
    .flags(flags), .flag_clr(flag_clr), .dir_q(dir_q), .out_q(out_q),
    .cfg_q(cfg_q), .msk0_q(msk0_q), .msk1_q(msk1_q),
    .irq_en_q(irq_en_q), .route_q(route_q)
  );

  gpio_sense #(.PINS(PINS)) u_sense (
    .clk(clk), .rst(rst), .pin_in(pin_in), .cfg(cfg_q),
    .flag_clr(flag_clr), .in_val(in_val), .sync_raw(sync_raw), .flags(flags)
  );

  gpio_drive #(.PINS(PINS), .CLK_PIN(CLK_PIN), .EVT_PIN(EVT_PIN)) u_drive (
    .clk(clk), .rst(rst), .dir(dir_q), .out(out_q), .cfg(cfg_q),
    .route(route_q), .clk_src(clk_src), .evt_src(evt_src),
    .sync_raw(sync_raw), .pin_out(pin_out), .pin_oe(pin_oe),
    .pull_en(pull_en), .pull_hi(pull_hi)
  );

  assign irq_n[0] = irq_en_q[0] & (|(flags & msk0_q));
  assign irq_n[1] = irq_en_q[1] & (|(flags & msk1_q));

  always_ff @(posedge clk) begin
    if (rst) irq <= '0;
    else     irq <= irq_n;
  end

  p_irq0_src_r6: assert property (@(posedge clk) disable iff (rst)
    irq[0] |-> $past(irq_en_q[0] && ((flags & msk0_q) != '0)));

  p_irq1_src_r6: assert property (@(posedge clk) disable iff (rst)
    irq[1] |-> $past(irq_en_q[1] && ((flags & msk1_q) != '0)));

endmodule

// File: tb/test_gpio_port_ctrl.sv
`timescale 1ns/1ps
module test_gpio_port_ctrl;

  logic       clk = 0;
  logic       rst = 1;
  logic       bus_we = 0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in = '0;
  logic [7:0] pin_out, pin_oe, pull_en, pull_hi;
  logic       clk_src = 0;
  logic       evt_src = 0;
  logic [1:0] irq;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  gpio_port_ctrl i_gpio_port_ctrl (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pull_en(pull_en), .pull_hi(pull_hi),
    .clk_src(clk_src), .evt_src(evt_src), .irq(irq)
  );

  task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%02h expected=%02h", req, what, got, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = 5'(a); bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = 5'(a);
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic cfg_pins(input logic [7:0] msk, input logic [7:0] c);
    wr(13, msk);
    wr(14, c);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst = 1; pin_in = '0; clk_src = 0; evt_src = 0; bus_we = 0;
    settle(3);
    rst = 0;
    settle(1);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    do_reset();
    chk("R1", "pin_oe", pin_oe, 8'h00);
    chk("R1", "pin_out", pin_out, 8'h00);
    chk("R1", "pull_en", pull_en, 8'h00);
    chk("R1", "irq", {6'b0, irq}, 8'h00);
    rd(0, d);  chk("R1", "dir", d, 8'h00);
    rd(4, d);  chk("R1", "out", d, 8'h00);
    rd(16, d); chk("R1", "cfg0", d, 8'h00);
    rd(9, d);  chk("R1", "flags", d, 8'h00);
  endtask

  task automatic t_aliases;
    logic [7:0] d;
    do_reset();
    wr(0, 8'hA5); rd(0, d); chk("R2", "dir write", d, 8'hA5);
    wr(1, 8'h0F); rd(1, d); chk("R2", "dir set", d, 8'hAF);
    wr(2, 8'h81); rd(2, d); chk("R2", "dir clr", d, 8'h2E);
    wr(3, 8'hFF); rd(3, d); chk("R2", "dir tgl", d, 8'hD1);
    wr(4, 8'h3C); wr(7, 8'h0F); rd(4, d); chk("R2", "out tgl", d, 8'h33);
    wr(5, 8'h80); rd(5, d); chk("R2", "out set", d, 8'hB3);
    wr(6, 8'h30); rd(6, d); chk("R2", "out clr", d, 8'h83);
    settle(1);
    chk("R8", "oe follows dir", pin_oe, 8'hD1);
    chk("R8", "totem value", pin_out, 8'h83 & 8'hD1);
    wr(0, 8'h00); settle(1);
    chk("R11", "dir clear no oe", pin_oe, 8'h00);
  endtask

  task automatic t_input;
    logic [7:0] d;
    do_reset();
    pin_in = 8'h5A;
    settle(1);
    bus_addr = 5'd8;
    @(negedge clk);
    chk("R3", "in after 1 edge", bus_rdata, 8'h00);
    settle(2);
    chk("R3", "in after sync", bus_rdata, 8'h5A);
    cfg_pins(8'h0F, 8'h80);
    rd(8, d); chk("R3", "in inverted low nibble", d, 8'h55);
    rd(17, d); chk("R7", "cfg1 readback", d, 8'h80);
  endtask

  task automatic t_sense;
    logic [7:0] d;
    do_reset();
    cfg_pins(8'h01, 8'h01);
    cfg_pins(8'h02, 8'h02);
    settle(3);
    wr(9, 8'hFF);
    @(negedge clk); pin_in = 8'h07;
    settle(5);
    rd(9, d); chk("R4", "rise: rise+both flags", d, 8'h05);
    wr(9, 8'hFF); rd(9, d); chk("R5", "write1 clears", d, 8'h00);
    @(negedge clk); pin_in = 8'h00;
    settle(5);
    rd(9, d); chk("R4", "fall: fall+both flags", d, 8'h06);
    wr(9, 8'h02); rd(9, d); chk("R5", "clear one bit only", d, 8'h04);
    cfg_pins(8'h08, 8'h81);
    settle(4);
    wr(9, 8'hFF);
    @(negedge clk); pin_in = 8'h08;
    settle(5);
    rd(9, d); chk("R4", "inverted rise not on pad rise", d, 8'h00);
    @(negedge clk); pin_in = 8'h00;
    settle(5);
    rd(9, d); chk("R4", "inverted rise on pad fall", d, 8'h08);
  endtask

  task automatic t_low_level;
    logic [7:0] d;
    do_reset();
    pin_in = 8'hDF;
    settle(4);
    cfg_pins(8'h20, 8'h03);
    settle(3);
    wr(9, 8'h20); rd(9, d); chk("R5", "low level re-sets flag", d & 8'h20, 8'h20);
    @(negedge clk); pin_in = 8'hFF;
    settle(5);
    wr(9, 8'h20); rd(9, d); chk("R5", "high clears for good", d & 8'h20, 8'h00);
  endtask

  task automatic t_irq;
    logic [7:0] d;
    do_reset();
    cfg_pins(8'h03, 8'h01);
    wr(10, 8'h01);
    wr(11, 8'h02);
    wr(12, 8'h03);
    rd(12, d); chk("R6", "enable readback", d, 8'h03);
    @(negedge clk); pin_in = 8'h01;
    settle(3);
    chk("R6", "irq not before flag+1", {6'b0, irq}, 8'h00);
    settle(1);
    chk("R6", "irq0 only", {6'b0, irq}, 8'h01);
    wr(12, 8'h00); settle(1);
    chk("R6", "disabled irq low", {6'b0, irq}, 8'h00);
    wr(12, 8'h03);
    @(negedge clk); pin_in = 8'h03;
    settle(4);
    chk("R6", "both irq", {6'b0, irq}, 8'h03);
    wr(9, 8'h01); settle(1);
    chk("R6", "irq0 drops on clear", {6'b0, irq}, 8'h02);
  endtask

  task automatic t_cfg_mask;
    logic [7:0] d;
    do_reset();
    cfg_pins(8'h0A, 8'hFF);
    rd(17, d); chk("R7", "pin1 masked write", d, 8'hBB);
    rd(19, d); chk("R7", "pin3 masked write", d, 8'hBB);
    rd(16, d); chk("R7", "pin0 untouched", d, 8'h00);
    cfg_pins(8'h02, 8'h12);
    rd(17, d); chk("R7", "pin1 rewritten", d, 8'h12);
    rd(19, d); chk("R7", "pin3 kept", d, 8'hBB);
  endtask

  task automatic t_drive;
    do_reset();
    cfg_pins(8'h04, 8'h18);
    cfg_pins(8'h08, 8'h20);
    wr(0, 8'h0F);
    wr(4, 8'h0F);
    settle(1);
    chk("R8", "oe high levels", pin_oe, 8'h0B);
    chk("R8", "val high levels", pin_out, 8'h0B);
    wr(6, 8'h0C); settle(1);
    chk("R8", "oe low levels", pin_oe, 8'h07);
    chk("R8", "val low levels", pin_out & pin_oe, 8'h03);
    cfg_pins(8'h01, 8'h80); settle(1);
    chk("R8", "inverted totem", pin_out & 8'h01, 8'h00);
  endtask

  task automatic t_pulls;
    do_reset();
    cfg_pins(8'h40, 8'h10);
    cfg_pins(8'h20, 8'h08);
    settle(1);
    chk("R9", "pull_en", pull_en, 8'h60);
    chk("R9", "pull_hi", pull_hi, 8'h40);
    chk("R9", "no oe", pin_oe, 8'h00);
    cfg_pins(8'h40, 8'h28);
    @(negedge clk); pin_in = 8'h40;
    settle(3);
    chk("R9", "keeper high", pull_hi & 8'h40, 8'h40);
    @(negedge clk); pin_in = 8'h00;
    settle(3);
    chk("R9", "keeper low", pull_hi & 8'h40, 8'h00);
    wr(0, 8'h60); settle(1);
    chk("R9", "pull off when output", pull_en, 8'h00);
  endtask

  task automatic t_route;
    do_reset();
    wr(0, 8'h90);
    wr(15, 8'h03);
    @(negedge clk); clk_src = 1; evt_src = 0;
    @(negedge clk);
    chk("R10", "clock on pin4", pin_out & 8'h90, 8'h10);
    clk_src = 0; evt_src = 1;
    @(negedge clk);
    chk("R10", "event on pin7", pin_out & 8'h90, 8'h80);
    cfg_pins(8'h80, 8'h80); settle(1);
    chk("R10", "event inverted", pin_out & 8'h80, 8'h00);
    wr(15, 8'h00); wr(4, 8'h10); settle(1);
    chk("R10", "route off uses out reg", pin_out & 8'h90, 8'h90);
  endtask

  initial begin
    t_reset();
    t_aliases();
    t_input();
    t_sense();
    t_low_level();
    t_irq();
    t_cfg_mask();
    t_drive();
    t_pulls();
    t_route();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule